// File: doc/BRIEF.md
# Row-to-Page Bitmap Transposer

This block turns a one-bit-per-pixel bitmap, kept row by row in a small byte RAM, into the byte order that a page-organised monochrome display controller takes. The panel is split into bands of eight pixel rows ("pages"). For every page and every column the block gathers eight vertically stacked pixels and sends them as one byte, with the top row in bit 0.

A transfer starts with a one-cycle `start` pulse that carries the rectangle width, the rectangle's first row and row count, and the panel height. The bitmap in RAM holds the rectangle's rows from the page-aligned first row down: row r, column j is bit (j mod 8) of byte r·ceil(width/8) + j/8. The block reads the RAM through a read port with one cycle of latency and sends bytes over a valid/ready stream. A byte is transferred on a rising edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the byte and its `out_last` flag stay unchanged. Once a byte is valid, it stays valid until it is accepted. `done` pulses after the final byte has been accepted.

Top module: `page_transposer`

## Requirements
- R1: In an output byte for page i and column j, bit k holds the pixel of buffer row 8·i+k, column j.
- R2: The pixel of buffer row r, column j is taken from bit (j mod 8) of RAM byte r·ceil(width/8) + floor(j/8), and the RAM data is used one cycle after `rd_en`.
- R3: The first row is rounded down to a multiple of 8. The page count is the number of 8-row pages from that aligned row to the rectangle's end row, rounded up. That end is clipped to the panel height rounded up to a full page.
- R4: When a page reaches past the panel height, only (panel height mod 8) rows are gathered. The higher bits of its bytes are 0, and no RAM read is issued for the missing rows.
- R5: Bytes leave in page-major order: columns 0..width-1 of page 0, then of page 1, and so on. The total is width × pages bytes.
- R6: While `out_valid` is high and `out_ready` is low, the next cycle still has `out_valid` high, with `out_data` and `out_last` unchanged.
- R7: `out_last` is high exactly on the byte for column width-1 of each page, and only when `out_valid` is high.
- R8: `done` is high for one cycle, in the cycle after the final byte is accepted. `busy` is high from the cycle after `start` until `done`.
- R9: A `start` pulse while `busy` is high is ignored: the running transfer keeps its geometry and its byte count.
- R10: After reset, `out_valid`, `busy`, `done` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a transfer with the geometry below |
| rect_w | input | W_W | Rectangle width in columns (1 or more) |
| rect_y | input | H_W | First rectangle row (below the panel height) |
| rect_h | input | H_W | Rectangle row count (1 or more) |
| panel_h | input | H_W | Panel height in rows |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| rd_en | output | 1 | RAM read strobe |
| rd_addr | output | ADDR_W | RAM byte address |
| rd_data | input | 8 | RAM read data, one cycle after rd_en |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Gathered column byte |
| out_last | output | 1 | Final byte of a page |

## Verification
The assertions check on every cycle that a stalled byte stays put (R6), that `out_last` appears only with valid data (R7), and that `done` always follows the acceptance of a last-flagged byte (R8). They also check that a `start` during a transfer leaves the latched geometry alone (R9). The bench's scenarios cover what depends on the RAM contents and on the geometry. This includes the bit gathering and addressing against a model of the bitmap (R1, R2), page-alignment and clipping counts (R3, R5), and the zeroed rows and suppressed reads of a partial page (R4).

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATHER,
    ST_DRAIN,
    ST_EMIT,
    ST_DONE
  } pt_state_e;
endpackage

// File: rtl/pt_geometry.sv
module pt_geometry #(
  parameter int W_W  = 8,
  parameter int H_W  = 8,
  parameter int PG_W = H_W - 1,
  parameter int LL_W = W_W - 2
) (
  input  logic [W_W-1:0]  w,
  input  logic [H_W-1:0]  y,
  input  logic [H_W-1:0]  h,
  input  logic [H_W-1:0]  ph,
  input  logic [PG_W-1:0] cur_pg,
  output logic [LL_W-1:0] line_len,
  output logic [PG_W-1:0] pages,
  output logic [3:0]      rows
);
  logic [W_W:0]    w_up;
  logic [H_W+1:0]  end_up;
  logic [H_W:0]    ph_up;
  logic [PG_W-1:0] first_pg, end_pg, panel_pg, lim_pg, abs_pg;
  logic [PG_W+3:0] abs_end_row;

  always_comb begin
    w_up     = {1'b0, w} + (W_W+1)'(7);
    line_len = w_up[W_W:3];
    first_pg = PG_W'(y[H_W-1:3]);
    end_up   = {2'b00, y} + {2'b00, h} + (H_W+2)'(7);
    end_pg   = PG_W'(end_up[H_W+1:3]);
    ph_up    = {1'b0, ph} + (H_W+1)'(7);
    panel_pg = PG_W'(ph_up[H_W:3]);
    lim_pg   = (end_pg < panel_pg) ? end_pg : panel_pg;
    pages    = lim_pg - first_pg;
    abs_pg   = first_pg + cur_pg;
    abs_end_row = {abs_pg + PG_W'(1), 3'b000};
    rows     = (abs_end_row > (PG_W+3)'(ph)) ? {1'b0, ph[2:0]} : 4'd8;
  end
endmodule

// File: rtl/pt_bit_gather.sv
module pt_bit_gather (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       rd_issue,
  input  logic [2:0] row_k,
  input  logic [2:0] bit_sel,
  input  logic [7:0] rd_data,
  output logic [7:0] byte_q
);
  logic       pend;
  logic [2:0] k_d, sel_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      k_d   <= '0;
      sel_d <= '0;
      byte_q <= '0;
    end else begin
      pend  <= rd_issue;
      k_d   <= row_k;
      sel_d <= bit_sel;
      if (clear) byte_q <= '0;
      else if (pend) byte_q[k_d] <= rd_data[sel_d];
    end
  end

  a_r2_no_clear_during_read: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !clear);
endmodule

// File: rtl/page_transposer.sv
module page_transposer #(
  parameter int W_W    = 8,
  parameter int H_W    = 8,
  parameter int ADDR_W = W_W + H_W - 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [W_W-1:0]    rect_w,
  input  logic [H_W-1:0]    rect_y,
  input  logic [H_W-1:0]    rect_h,
  input  logic [H_W-1:0]    panel_h,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last
);
  import pt_pkg::*;
  localparam int PG_W  = H_W - 1;
  localparam int LL_W  = W_W - 2;
  localparam int PRD_W = PG_W + 3 + LL_W + 1;

  pt_state_e       state;
  logic [W_W-1:0]  w_q, col;
  logic [H_W-1:0]  y_q, h_q, ph_q;
  logic [PG_W-1:0] pg, pages;
  logic [LL_W-1:0] line_len;
  logic [3:0]      rows;
  logic [2:0]      k;
  logic            accept, col_end, pg_end;
  logic [PRD_W-1:0] addr_full;

  pt_geometry #(.W_W(W_W), .H_W(H_W), .PG_W(PG_W), .LL_W(LL_W)) i_geom (
    .w(w_q), .y(y_q), .h(h_q), .ph(ph_q), .cur_pg(pg),
    .line_len(line_len), .pages(pages), .rows(rows)
  );

  assign accept  = (state == ST_EMIT) && out_ready;
  assign col_end = (col == w_q - W_W'(1));
  assign pg_end  = (pg == pages - PG_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      w_q <= '0; y_q <= '0; h_q <= '0; ph_q <= '0;
      col <= '0; pg <= '0; k <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          w_q <= rect_w; y_q <= rect_y; h_q <= rect_h; ph_q <= panel_h;
          col <= '0; pg <= '0; k <= '0;
          state <= ST_GATHER;
        end
        ST_GATHER: begin
          k <= k + 3'd1;
          if (k == 3'd7) state <= ST_DRAIN;
        end
        ST_DRAIN: state <= ST_EMIT;
        ST_EMIT: if (out_ready) begin
          k <= '0;
          if (col_end) begin
            col <= '0;
            if (pg_end) state <= ST_DONE;
            else begin
              pg <= pg + PG_W'(1);
              state <= ST_GATHER;
            end
          end else begin
            col <= col + W_W'(1);
            state <= ST_GATHER;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    rd_en     = (state == ST_GATHER) && ({1'b0, k} < rows);
    addr_full = PRD_W'({pg, k}) * PRD_W'(line_len) + PRD_W'(col[W_W-1:3]);
    rd_addr   = ADDR_W'(addr_full);
    out_valid = (state == ST_EMIT);
    out_last  = out_valid && col_end;
    busy      = (state != ST_IDLE);
    done      = (state == ST_DONE);
  end

  pt_bit_gather i_gather (
    .clk(clk), .rst_n(rst_n), .clear(accept), .rd_issue(rd_en),
    .row_k(k), .bit_sel(col[2:0]), .rd_data(rd_data), .byte_q(out_data)
  );

  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  a_r7_last_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && out_last));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(w_q) && $stable(h_q) && $stable(ph_q)));
endmodule

// File: tb/test_page_transposer.sv
module test_page_transposer;
  localparam int CLK_PERIOD = 10;
  localparam int W_W = 8;
  localparam int H_W = 8;
  localparam int ADDR_W = W_W + H_W - 3;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [W_W-1:0] rect_w = '0;
  logic [H_W-1:0] rect_y = '0, rect_h = '0, panel_h = '0;
  logic busy, done, rd_en, out_valid, out_ready = 1'b0, out_last;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0] rd_data, out_data;
  logic [7:0] mem [0:1023];
  int checks = 0, errors = 0, cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_ff @(posedge clk) if (rd_en) rd_data <= mem[rd_addr[9:0]];

  page_transposer #(.W_W(W_W), .H_W(H_W), .ADDR_W(ADDR_W)) i_page_transposer (
    .clk(clk), .rst_n(rst_n), .start(start), .rect_w(rect_w), .rect_y(rect_y),
    .rect_h(rect_h), .panel_h(panel_h), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pages(int w, int y, int h, int ph);
    int y0 = (y / 8) * 8;
    int e = ((y + h + 7) / 8) * 8;
    int pe = ((ph + 7) / 8) * 8;
    if (e > pe) e = pe;
    return (e - y0 + 7) / 8;
  endfunction

  function automatic int rows_in(int y, int ph, int pg);
    int absp = y / 8 + pg;
    return (8 * (absp + 1) > ph) ? (ph % 8) : 8;
  endfunction

  function automatic logic [7:0] exp_byte(int w, int y, int ph, int pg, int col);
    int ll = (w + 7) / 8;
    int m = rows_in(y, ph, pg);
    logic [7:0] b = '0;
    for (int k = 0; k < m; k++) b[k] = mem[(8 * pg + k) * ll + col / 8][col % 8];
    return b;
  endfunction

  // One transfer: stimulus, collection and checks.
  task automatic run_job(input int w, input int y, input int h, input int ph,
                         input bit stall, input bit inject, input string tag);
    int pages = exp_pages(w, y, h, ph);
    int total = w * pages;
    int n = 0, rdcnt = 0, exp_rd = 0, donecnt = 0, holdbad = 0, bytebad = 0, lastbad = 0;
    int cyc = 0;
    bit pv = 0, pr = 0, pl = 0;
    logic [7:0] pd = '0;
    for (int p = 0; p < pages; p++) exp_rd += w * rows_in(y, ph, p);
    @(negedge clk);
    rect_w = W_W'(w); rect_y = H_W'(y); rect_h = H_W'(h); panel_h = H_W'(ph);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy == 1'b1, {"R8 busy after start ", tag}, int'(busy), 1);
    while (donecnt == 0 && cyc < 20000) begin
      out_ready = stall ? ((cyc % 3) != 0) : 1'b1;
      if (inject) begin
        start = (cyc == 15);
        rect_w = (cyc == 15) ? W_W'(99) : W_W'(w);
      end
      if (rd_en) rdcnt++;
      if (pv && !pr && (!out_valid || out_data != pd || out_last != pl)) holdbad++;
      if (out_valid && out_ready) begin
        if (n < total) begin
          if (out_data != exp_byte(w, y, ph, n / w, n % w)) begin
            bytebad++;
            $display("FAIL R1/R2 %s byte %0d actual=%0h expected=%0h", tag, n,
                     out_data, exp_byte(w, y, ph, n / w, n % w));
          end
          if (out_last != ((n % w) == w - 1)) lastbad++;
        end
        n++;
      end
      if (done) begin
        donecnt++;
        check(n == total, {"R5/R8 bytes before done ", tag}, n, total);
      end
      pv = out_valid; pr = out_ready; pd = out_data; pl = out_last;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    checks++;
    if (bytebad != 0) errors++;
    check(donecnt == 1, {"R8 done seen ", tag}, donecnt, 1);
    check(n == total, {"R5 byte count ", tag}, n, total);
    check(lastbad == 0, {"R7 last flags ", tag}, lastbad, 0);
    check(holdbad == 0, {"R6 stall hold ", tag}, holdbad, 0);
    check(rdcnt == exp_rd, {"R4 read count ", tag}, rdcnt, exp_rd);
    check(!done && !busy, {"R8 idle after done ", tag}, int'(busy), 0);
  endtask

  task automatic t_reset;
    check(!out_valid && !busy && !done && !rd_en, "R10 reset state", int'(out_valid | busy | done | rd_en), 0);
  endtask

  task automatic t_full_pages;   // R1 R2 R5
    run_job(16, 0, 16, 64, 1'b0, 1'b0, "full");
  endtask

  task automatic t_narrow_stall; // R6 R7
    run_job(5, 0, 8, 64, 1'b1, 1'b0, "stall");
  endtask

  task automatic t_unaligned_y;  // R3
    check(exp_pages(3, 3, 7, 64) == 2, "R3 aligned page count model", exp_pages(3, 3, 7, 64), 2);
    run_job(3, 3, 7, 64, 1'b0, 1'b0, "unaligned");
  endtask

  task automatic t_partial_page; // R4
    run_job(4, 0, 16, 12, 1'b1, 1'b0, "partial");
  endtask

  task automatic t_clip;         // R3
    run_job(9, 0, 24, 16, 1'b0, 1'b0, "clip");
  endtask

  task automatic t_start_busy;   // R9
    run_job(10, 8, 8, 64, 1'b0, 1'b1, "R9 restart");
  endtask

  initial begin
    for (int a = 0; a < 1024; a++) mem[a] = 8'((a * 37 + 5) ^ (a >> 3));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_full_pages();
    t_narrow_stall();
    t_unaligned_y();
    t_partial_page();
    t_clip();
    t_start_busy();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule